// File: doc/BRIEF.md
# Keyed Clock-Gating Request Controller

This block owns the clock enables of five accelerator engines. Software writes a request register with one bit per engine. A 1 asks for that engine's clock to run and a 0 asks for it to stop. A second register picks, per engine, how the stop and start happen. In direct mode the enable simply tracks the request bit. In handshake mode the controller first raises an idle request to the engine and waits for the engine's idle acknowledge before it removes the clock. When it starts the clock again, it turns the clock on before it drops the idle request.

A write to the request register carries a 4-bit key in the top nibble of the data word. Key 0x5 turns the write into a bit-set. Key 0x2 turns it into a bit-clear. Any other key stores the low bits as they are. With set and clear, several software agents can each change their own engine without a read-modify-write race. The clock-gating cells are not part of the block. Each engine gets one enable output to feed such a cell.

The register bus is plain: select, write strobe, word address, write data, and a combinational read data path. The block carries no data stream, so it has no valid/ready interface and no back-pressure.

Top module: `clkgate_req_ctrl`

## Requirements
- R1: After reset, the request and configuration registers read as zero, every `clk_en` bit is 0 and every `idle_req` bit is 0.
- R2: `bus_rdata` returns the configuration register in bits [4:0] at offset 0x0 and the request register in bits [4:0] at offset 0x4. All other bits, including the key field [31:28], read as zero. Any other offset reads as zero.
- R3: A write to offset 0x4 with bits [31:28] = 0x5 sets each request bit whose data bit [4:0] is 1 and leaves the others unchanged.
- R4: A write to offset 0x4 with bits [31:28] = 0x2 clears each request bit whose data bit [4:0] is 1 and leaves the others unchanged.
- R5: A write to offset 0x4 with any other key loads data bits [4:0] into the request register. A write to offset 0x0 loads data bits [4:0] into the configuration register, where 1 selects handshake mode for that engine.
- R6: A cycle with `bus_wr` low, or a write to an offset other than 0x0 or 0x4, changes neither register.
- R7: For an engine in direct mode, `clk_en` equals its request bit one cycle after that bit changes, and `idle_req` stays low.
- R8: For an engine in handshake mode, clearing its request raises `idle_req` one cycle after the register changes while `clk_en` stays 1. `clk_en` falls only in the cycle after `idle_ack` is sampled high. `idle_req` then stays high while the engine is gated.
- R9: For an engine that was gated in handshake mode, setting its request raises `clk_en` with `idle_req` still high. `idle_req` falls one cycle later.
- R10: If the request bit is set again while the controller is still waiting for `idle_ack`, the engine returns to running: `idle_req` falls and `clk_en` never drops. A re-set request wins over an acknowledge that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data; bits [31:28] are the key |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| idle_ack | input | 5 | Per-engine idle acknowledge |
| clk_en | output | 5 | Per-engine clock enable |
| idle_req | output | 5 | Per-engine idle request |

## Verification
The bench goes after the points where a plausible design goes wrong:
- **Keyed updates.** It checks that a set or a clear touches only the bits written as 1. A design that treated keyed writes as plain loads would wipe the neighbouring engines' requests.
- **Gating order.** It holds `idle_ack` low for several cycles while a stop is pending. A controller that gated without waiting would drop `clk_en` early.
- **Un-gating order.** It samples the single cycle in which `clk_en` is already high and `idle_req` is still high. A design that released both together, or in the wrong order, fails there.
- **Abort.** It cancels a pending stop and checks that the engine resumes without a gap in its clock.

// File: rtl/cg_ctrl_pkg.sv
package cg_ctrl_pkg;

  localparam int WORD_W  = 32;
  localparam int KEY_W   = 4;
  localparam int KEY_LSB = WORD_W - KEY_W;

  localparam logic [KEY_W-1:0] KEY_SET = 4'h5;
  localparam logic [KEY_W-1:0] KEY_CLR = 4'h2;

  typedef enum logic [1:0] {
    UPD_LOAD,
    UPD_SET,
    UPD_CLR
  } upd_op_e;

  typedef enum logic [2:0] {
    ST_OFF,     // gated, no handshake pending
    ST_OFF_HS,  // gated after handshake, idle request held
    ST_ON,      // running
    ST_DRAIN,   // running, idle request out, waiting for ack
    ST_WAKE     // clock restored, idle request still high
  } eng_state_e;

  function automatic upd_op_e key_to_op(input logic [KEY_W-1:0] key);
    if (key == KEY_SET)      return UPD_SET;
    else if (key == KEY_CLR) return UPD_CLR;
    else                     return UPD_LOAD;
  endfunction

endpackage

// File: rtl/cg_key_update.sv
module cg_key_update
  import cg_ctrl_pkg::*;
#(
  parameter int N_ENG = 5
) (
  input  logic [N_ENG-1:0] cur_bits,
  input  logic [N_ENG-1:0] wr_bits,
  input  logic [KEY_W-1:0] key,
  output logic [N_ENG-1:0] nxt_bits
);

  upd_op_e op;

  always_comb begin
    op = key_to_op(key);
    unique case (op)
      UPD_SET: nxt_bits = cur_bits | wr_bits;
      UPD_CLR: nxt_bits = cur_bits & ~wr_bits;
      default: nxt_bits = wr_bits;
    endcase
  end

endmodule

// File: rtl/cg_regfile.sv
module cg_regfile
  import cg_ctrl_pkg::*;
#(
  parameter int N_ENG  = 5,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CFG_OFS = 'h0,
  parameter logic [ADDR_W-1:0] REQ_OFS = 'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [N_ENG-1:0]  req_q,
  output logic [N_ENG-1:0]  cfg_q
);

  localparam int PAD_W = WORD_W - N_ENG;

  logic             wr_req;
  logic             wr_cfg;
  logic [N_ENG-1:0] req_nxt;
  logic             unused_mid;

  assign wr_req = bus_sel && bus_wr && (bus_addr == REQ_OFS);
  assign wr_cfg = bus_sel && bus_wr && (bus_addr == CFG_OFS);

  assign unused_mid = ^bus_wdata[KEY_LSB-1:N_ENG];

  cg_key_update #(.N_ENG(N_ENG)) u_keyupd (
    .cur_bits (req_q),
    .wr_bits  (bus_wdata[N_ENG-1:0]),
    .key      (bus_wdata[WORD_W-1:KEY_LSB]),
    .nxt_bits (req_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      cfg_q <= '0;
    end else begin
      if (wr_req) req_q <= req_nxt;
      if (wr_cfg) cfg_q <= bus_wdata[N_ENG-1:0];
    end
  end

  always_comb begin
    if (bus_addr == CFG_OFS)      bus_rdata = {{PAD_W{1'b0}}, cfg_q};
    else if (bus_addr == REQ_OFS) bus_rdata = {{PAD_W{1'b0}}, req_q};
    else                          bus_rdata = '0;
  end

endmodule

// File: rtl/cg_engine_seq.sv
module cg_engine_seq
  import cg_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  input  logic hs_mode,
  input  logic idle_ack,
  output logic clk_en,
  output logic idle_req
);

  eng_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:    if (run_req) state_d = ST_ON;
      ST_OFF_HS: if (run_req) state_d = ST_WAKE;
      ST_ON:     if (!run_req) state_d = hs_mode ? ST_DRAIN : ST_OFF;
      ST_DRAIN: begin
        if (run_req)       state_d = ST_ON;
        else if (idle_ack) state_d = ST_OFF_HS;
      end
      ST_WAKE:   state_d = ST_ON;
      default:   state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign clk_en   = (state_q == ST_ON) || (state_q == ST_DRAIN) || (state_q == ST_WAKE);
  assign idle_req = (state_q == ST_DRAIN) || (state_q == ST_OFF_HS) || (state_q == ST_WAKE);

endmodule

// File: rtl/clkgate_req_ctrl.sv
module clkgate_req_ctrl
  import cg_ctrl_pkg::*;
#(
  parameter int N_ENG  = 5,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_ENG-1:0]  idle_ack,
  output logic [N_ENG-1:0]  clk_en,
  output logic [N_ENG-1:0]  idle_req
);

  localparam logic [ADDR_W-1:0] CFG_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] REQ_OFS = ADDR_W'(4);

  logic [N_ENG-1:0] req_q;
  logic [N_ENG-1:0] cfg_q;

  cg_regfile #(
    .N_ENG   (N_ENG),
    .ADDR_W  (ADDR_W),
    .CFG_OFS (CFG_OFS),
    .REQ_OFS (REQ_OFS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .req_q     (req_q),
    .cfg_q     (cfg_q)
  );

  for (genvar g = 0; g < N_ENG; g++) begin : g_eng
    cg_engine_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_req  (req_q[g]),
      .hs_mode  (cfg_q[g]),
      .idle_ack (idle_ack[g]),
      .clk_en   (clk_en[g]),
      .idle_req (idle_req[g])
    );
  end

endmodule

// File: rtl/cg_ctrl_chk.sv
module cg_ctrl_chk #(
  parameter int N_ENG  = 5,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [N_ENG-1:0]  idle_ack,
  input logic [N_ENG-1:0]  clk_en,
  input logic [N_ENG-1:0]  idle_req,
  input logic [N_ENG-1:0]  req_q,
  input logic [N_ENG-1:0]  cfg_q
);

  logic req_wr;
  assign req_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(4));

  p_key_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:28] == 4'h0);

  p_key_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && bus_wdata[31:28] == 4'h5) |=> req_q == $past(req_q | bus_wdata[N_ENG-1:0]));

  p_key_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && bus_wdata[31:28] == 4'h2) |=> req_q == $past(req_q & ~bus_wdata[N_ENG-1:0]));

  p_plain_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && bus_wdata[31:28] != 4'h5 && bus_wdata[31:28] != 4'h2)
      |=> req_q == $past(bus_wdata[N_ENG-1:0]));

  p_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> ($stable(req_q) && $stable(cfg_q)));

  for (genvar g = 0; g < N_ENG; g++) begin : g_chk
    p_direct_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_q[g] && !$past(cfg_q[g]) && !idle_req[g] && !$past(idle_req[g]))
        |-> clk_en[g] == $past(req_q[g]));

    p_gate_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(clk_en[g]) && $past(idle_req[g])) |-> $past(idle_ack[g]));

    p_ungate_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(idle_req[g]) |-> (clk_en[g] && $past(clk_en[g])));
  end

endmodule

bind clkgate_req_ctrl cg_ctrl_chk #(.N_ENG(N_ENG), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .idle_ack  (idle_ack),
  .clk_en    (clk_en),
  .idle_req  (idle_req),
  .req_q     (req_q),
  .cfg_q     (cfg_q)
);

// File: tb/clkgate_req_ctrl_bench.sv
`timescale 1ns/1ps
module clkgate_req_ctrl_bench;

  localparam int N = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] idle_ack = '0;
  logic [N-1:0] clk_en;
  logic [N-1:0] idle_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  clkgate_req_ctrl u_clkgate_req_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .idle_ack(idle_ack), .clk_en(clk_en), .idle_req(idle_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Drives one write cycle; returns at the negedge after the capturing edge.
  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    bus_read(4'h0, r); chk("R1 cfg after reset", r, 32'h0);
    bus_read(4'h4, r); chk("R1 req after reset", r, 32'h0);
    chk("R1 clk_en after reset", {27'b0, clk_en}, 32'h0);
    chk("R1 idle_req after reset", {27'b0, idle_req}, 32'h0);
  endtask

  task automatic t_plain_write();
    logic [31:0] r;
    bus_write(4'h4, 32'hF000_0015);
    bus_read(4'h4, r); chk("R5 plain load key F, R2 key reads zero", r, 32'h15);
    bus_write(4'h4, 32'h0FFF_FF09);
    bus_read(4'h4, r); chk("R5 plain load key 0", r, 32'h09);
    bus_write(4'h0, 32'h0000_0003);
    bus_read(4'h0, r); chk("R5 R2 cfg load/readback", r, 32'h03);
    bus_read(4'hC, r); chk("R2 unmapped read zero", r, 32'h0);
    bus_write(4'h0, 32'h0);
  endtask

  task automatic t_key_set();
    logic [31:0] r;
    bus_write(4'h4, 32'h0000_0011);
    bus_write(4'h4, 32'h5000_0006);
    bus_read(4'h4, r); chk("R3 keyed set", r, 32'h17);
  endtask

  task automatic t_key_clear();
    logic [31:0] r;
    bus_write(4'h4, 32'h2000_0005);
    bus_read(4'h4, r); chk("R4 keyed clear", r, 32'h12);
  endtask

  task automatic t_ignored();
    logic [31:0] r;
    bus_write(4'h8, 32'h0000_001F);
    bus_write(4'hC, 32'h5000_001F);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'h4; bus_wdata = 32'h0000_001F;
    @(negedge clk);
    bus_sel = 1'b0; bus_wdata = '0;
    bus_read(4'h4, r); chk("R6 req unchanged", r, 32'h12);
    bus_read(4'h0, r); chk("R6 cfg unchanged", r, 32'h0);
  endtask

  task automatic t_direct();
    bus_write(4'h4, 32'h0000_0000);
    @(negedge clk);
    chk("R7 direct all gated", {27'b0, clk_en}, 32'h0);
    bus_write(4'h4, 32'h0000_000A);
    chk("R7 clk_en not yet changed", {27'b0, clk_en}, 32'h0);
    @(negedge clk);
    chk("R7 clk_en follows req", {27'b0, clk_en}, 32'h0A);
    chk("R7 idle_req low", {27'b0, idle_req}, 32'h0);
    idle_ack = 5'h1F;
    bus_write(4'h4, 32'h0000_0015);
    @(negedge clk);
    chk("R7 clk_en follows new req", {27'b0, clk_en}, 32'h15);
    chk("R7 idle_req low with ack", {27'b0, idle_req}, 32'h0);
    idle_ack = '0;
    bus_write(4'h4, 32'h0);
    @(negedge clk);
  endtask

  task automatic t_handshake();
    bus_write(4'h0, 32'h0000_0001);
    bus_write(4'h4, 32'h5000_0001);
    @(negedge clk);
    chk("R8 engine0 running", {31'b0, clk_en[0]}, 32'h1);
    bus_write(4'h4, 32'h2000_0001);
    @(negedge clk);
    chk("R8 idle_req raised", {31'b0, idle_req[0]}, 32'h1);
    chk("R8 clk_en held", {31'b0, clk_en[0]}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R8 clk_en held without ack", {31'b0, clk_en[0]}, 32'h1);
    idle_ack[0] = 1'b1;
    @(negedge clk);
    idle_ack[0] = 1'b0;
    chk("R8 gated after ack", {31'b0, clk_en[0]}, 32'h0);
    chk("R8 idle_req held while gated", {31'b0, idle_req[0]}, 32'h1);
    bus_write(4'h4, 32'h5000_0001);
    @(negedge clk);
    chk("R9 clk_en on first", {31'b0, clk_en[0]}, 32'h1);
    chk("R9 idle_req still high", {31'b0, idle_req[0]}, 32'h1);
    @(negedge clk);
    chk("R9 idle_req dropped", {31'b0, idle_req[0]}, 32'h0);
    chk("R9 clk_en stays on", {31'b0, clk_en[0]}, 32'h1);
  endtask

  task automatic t_abort();
    bus_write(4'h4, 32'h2000_0001);
    @(negedge clk);
    chk("R10 draining", {30'b0, idle_req[0], clk_en[0]}, 32'h3);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h5000_0001;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    idle_ack[0] = 1'b1;
    chk("R10 clk_en on during abort", {31'b0, clk_en[0]}, 32'h1);
    @(negedge clk);
    idle_ack[0] = 1'b0;
    chk("R10 resumed clk_en", {31'b0, clk_en[0]}, 32'h1);
    chk("R10 idle_req dropped", {31'b0, idle_req[0]}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_write();
    t_key_set();
    t_key_clear();
    t_ignored();
    t_direct();
    t_handshake();
    t_abort();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule